// File: doc/BRIEF.md
# Nibble-Addressed Streaming SRAM Bridge

This block sits between a host's 8-bit parallel port and a byte-wide asynchronous SRAM and makes the memory look like a sequential-access ramdisk. The host never presents an address in parallel. With its address-select line high it writes a 24-bit pointer into the bridge as six 4-bit pieces. The most significant piece comes first, and each piece travels on the low half of the data bus. With the select line low, every read or write strobe moves one byte at the pointer and the pointer then steps forward by one. A whole block streams through with no per-byte addressing.

Both host strobes are active low and idle high. The SRAM control pins follow the raw host strobes combinationally, so the SRAM access lasts exactly as long as the host pulse. Read pulses therefore need to be longer than write pulses to cover the SRAM access time. The bookkeeping runs in the bridge clock domain. The strobes and the select line pass through a two-stage synchroniser, and the pointer and the piece counter act only on the detected release of a strobe. A read strobe in either mode restarts the address-piece sequence, so a dummy read before a pointer load puts the loader into a known state.

The port is strobe-driven rather than valid/ready. The host sets the pace and there is no back-pressure. Between the release of one strobe and the start of the next, the host leaves at least four bridge clock cycles. It also keeps the select line and the data bus steady for that gap.

Top module: `nibble_sram_bridge`

## Requirements
- R1: After reset the pointer is zero and `sram_addr` reads 0. `sram_ce_n`, `sram_oe_n` and `sram_we_n` are high, and `host_d_oe` and `sram_dq_oe` are low.
- R2: While `host_asel` is 1, each write strobe shifts the pointer left by 4 and puts bits [3:0] of `host_d_in` into the pointer's bottom 4 bits. Bits [7:4] are ignored. Six such writes load a full 24-bit pointer, most significant piece first.
- R3: A write strobe with `host_asel` = 1 leaves `sram_we_n` and `sram_ce_n` high and `sram_dq_oe` low.
- R4: A write strobe with `host_asel` = 0 pulls `sram_we_n` and `sram_ce_n` low and sets `sram_dq_oe` for as long as `host_wr_n` is low. During that time `sram_dq_out` equals `host_d_in` and `sram_addr` holds the pointer. `sram_we_n` and `sram_oe_n` are never low together.
- R5: A read strobe with `host_asel` = 0 pulls `sram_oe_n` and `sram_ce_n` low and raises `host_d_oe` while `host_rd_n` is low. During that time `host_d_out` carries `sram_dq_in` from the location at the pointer.
- R6: Each data read or data write strobe advances the pointer by exactly one, however long the strobe lasts. The pointer, and so `sram_addr`, stays stable while the strobe is low and changes only after release.
- R7: A sequence accepts at most six pointer pieces; further piece writes leave the pointer unchanged. Any read strobe, in either mode, restarts the sequence. A read strobe with `host_asel` = 1 leaves the pointer unchanged and does not drive the host bus.
- R8: The pointer wraps modulo 2^24. `sram_addr` is the low 23 pointer bits, so pointer bit 23 never reaches the SRAM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_d_in | input | 8 | Host data bus, host to bridge |
| host_d_out | output | 8 | Host data bus, bridge to host |
| host_d_oe | output | 1 | Bridge drives the host data bus |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe, active low |
| host_asel | input | 1 | 1: strobe writes load pointer pieces; 0: data access |
| sram_addr | output | 23 | SRAM address |
| sram_dq_in | input | 8 | SRAM data, memory to bridge |
| sram_dq_out | output | 8 | SRAM data, bridge to memory |
| sram_dq_oe | output | 1 | Bridge drives the SRAM data bus |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The bench goes after the piece ordering, using junk in the upper data nibble. A loader that took the wrong half, or pieces least significant first, would point at the wrong address. It writes a seventh piece with no read in between: a loader that kept shifting would drop the top piece. It then checks that a dummy read with the select line high restarts loading without moving the pointer or driving the bus. It holds one read strobe low for many cycles, where a level-triggered incrementer would run away. It also loads the all-ones pointer and writes through it, to expose a wrong wrap or the top bit leaking onto the 23-bit SRAM address.

// File: rtl/nsb_pkg.sv
package nsb_pkg;
  localparam int PTR_W_DEF  = 24;
  localparam int NIB_W_DEF  = 4;
  localparam int ADDR_W_DEF = 23;
  localparam int DATA_W_DEF = 8;

  typedef struct packed {
    logic rd_n;
    logic wr_n;
    logic asel;
  } host_ctl_t;

  localparam host_ctl_t CTL_IDLE = '{rd_n: 1'b1, wr_n: 1'b1, asel: 1'b0};
endpackage

// File: rtl/nsb_sync.sv
module nsb_sync #(
  parameter int          W       = 3,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nsb_ptr_loader.sv
module nsb_ptr_loader #(
  parameter int PTR_W  = 24,
  parameter int NIB_W  = 4,
  parameter int ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_n_s,
  input  logic              wr_n_s,
  input  logic              asel_s,
  input  logic [NIB_W-1:0]  nib_in,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int NIB_CNT = PTR_W / NIB_W;
  localparam int CNT_W   = $clog2(NIB_CNT + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(NIB_CNT);

  logic [PTR_W-1:0] ptr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             rd_prev_q, wr_prev_q;
  logic             rd_rise, wr_rise, nib_step, data_step, nib_ok;

  // release of an active-low strobe seen in the bridge domain
  assign rd_rise   = rd_n_s & ~rd_prev_q;
  assign wr_rise   = wr_n_s & ~wr_prev_q;
  assign nib_step  = wr_rise & asel_s;
  assign data_step = (rd_rise | wr_rise) & ~asel_s;
  assign nib_ok    = nib_step && (cnt_q < CNT_FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_prev_q <= 1'b1;
      wr_prev_q <= 1'b1;
      ptr_q     <= '0;
      cnt_q     <= '0;
    end else begin
      rd_prev_q <= rd_n_s;
      wr_prev_q <= wr_n_s;
      if (nib_ok)
        ptr_q <= {ptr_q[PTR_W-NIB_W-1:0], nib_in};
      else if (data_step)
        ptr_q <= ptr_q + 1'b1;
      if (rd_rise)
        cnt_q <= '0;
      else if (nib_ok)
        cnt_q <= cnt_q + 1'b1;
    end
  end

  assign addr_o = ptr_q[ADDR_W-1:0];

  // R7
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_FULL);

  // R7
  nib_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_FULL && nib_step && !rd_rise) |=> $stable(ptr_q));

  // R8
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((&ptr_q) && data_step && !nib_step) |=> (ptr_q == '0));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_s && !wr_prev_q == 1'b0 && !rd_prev_q) |=> $stable(ptr_q));
endmodule

// File: rtl/nsb_sram_ctrl.sv
module nsb_sram_ctrl #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              host_asel,
  input  logic [DATA_W-1:0] host_d_in,
  output logic [DATA_W-1:0] host_d_out,
  output logic              host_d_oe,
  input  logic [ADDR_W-1:0] ptr_addr,
  output logic [ADDR_W-1:0] sram_addr,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n
);
  logic rd_act, wr_act;

  // a read strobe wins if the host ever drives both
  assign rd_act = ~host_rd_n & ~host_asel;
  assign wr_act = ~host_wr_n & ~host_asel & host_rd_n;

  always_comb begin
    sram_addr   = ptr_addr;
    sram_dq_out = host_d_in;
    sram_dq_oe  = wr_act;
    sram_we_n   = ~wr_act;
    sram_oe_n   = ~rd_act;
    sram_ce_n   = ~(rd_act | wr_act);
    host_d_oe   = rd_act;
    host_d_out  = rd_act ? sram_dq_in : '0;
  end

  // R4
  we_oe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sram_we_n && !sram_oe_n));

  // R5
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd_n && !host_asel) |-> (host_d_oe && !sram_ce_n));

  // R3
  nib_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_asel |-> (sram_we_n && sram_ce_n && !sram_dq_oe));
endmodule

// File: rtl/nibble_sram_bridge.sv
module nibble_sram_bridge
  import nsb_pkg::*;
#(
  parameter int PTR_W       = PTR_W_DEF,
  parameter int NIB_W       = NIB_W_DEF,
  parameter int ADDR_W      = ADDR_W_DEF,
  parameter int DATA_W      = DATA_W_DEF,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] host_d_in,
  output logic [DATA_W-1:0] host_d_out,
  output logic              host_d_oe,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic              host_asel,
  output logic [ADDR_W-1:0] sram_addr,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n
);
  localparam int CTL_W = $bits(host_ctl_t);

  host_ctl_t         ctl_raw, ctl_s;
  logic [NIB_W-1:0]  nib_q;
  logic [ADDR_W-1:0] ptr_addr;

  assign ctl_raw = '{rd_n: host_rd_n, wr_n: host_wr_n, asel: host_asel};

  nsb_sync #(
    .W       (CTL_W),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (CTL_IDLE)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ctl_raw),
    .q     (ctl_s)
  );

  // piece captured while the raw write strobe is low; held steady by the host
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          nib_q <= '0;
    else if (!host_wr_n) nib_q <= host_d_in[NIB_W-1:0];
  end

  nsb_ptr_loader #(
    .PTR_W  (PTR_W),
    .NIB_W  (NIB_W),
    .ADDR_W (ADDR_W)
  ) u_ptr (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_n_s (ctl_s.rd_n),
    .wr_n_s (ctl_s.wr_n),
    .asel_s (ctl_s.asel),
    .nib_in (nib_q),
    .addr_o (ptr_addr)
  );

  nsb_sram_ctrl #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_rd_n   (host_rd_n),
    .host_wr_n   (host_wr_n),
    .host_asel   (host_asel),
    .host_d_in   (host_d_in),
    .host_d_out  (host_d_out),
    .host_d_oe   (host_d_oe),
    .ptr_addr    (ptr_addr),
    .sram_addr   (sram_addr),
    .sram_dq_in  (sram_dq_in),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe),
    .sram_ce_n   (sram_ce_n),
    .sram_oe_n   (sram_oe_n),
    .sram_we_n   (sram_we_n)
  );

  // R6
  addr_stable_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_we_n && $past(!sram_we_n)) |-> $stable(sram_addr));
endmodule

// File: tb/nibble_sram_bridge_bench.sv
module nibble_sram_bridge_bench;
  localparam int CLK_PERIOD = 10;
  localparam int GAP        = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_d_in = 8'h00;
  logic [7:0]  host_d_out;
  logic        host_d_oe;
  logic        host_rd_n = 1'b1;
  logic        host_wr_n = 1'b1;
  logic        host_asel = 1'b0;
  logic [22:0] sram_addr;
  logic [7:0]  sram_dq_in;
  logic [7:0]  sram_dq_out;
  logic        sram_dq_oe, sram_ce_n, sram_oe_n, sram_we_n;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0] mem [256];

  // snapshots taken while a strobe is low
  logic [22:0] s_addr_first, s_addr;
  logic [7:0]  s_d_out, s_dq_out;
  logic        s_d_oe, s_dq_oe, s_ce_n, s_oe_n, s_we_n;

  always #(CLK_PERIOD/2) clk = ~clk;

  nibble_sram_bridge u_nibble_sram_bridge (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_d_in   (host_d_in),
    .host_d_out  (host_d_out),
    .host_d_oe   (host_d_oe),
    .host_rd_n   (host_rd_n),
    .host_wr_n   (host_wr_n),
    .host_asel   (host_asel),
    .sram_addr   (sram_addr),
    .sram_dq_in  (sram_dq_in),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe),
    .sram_ce_n   (sram_ce_n),
    .sram_oe_n   (sram_oe_n),
    .sram_we_n   (sram_we_n)
  );

  // behavioural SRAM, 256 bytes decoded from the low address bits
  assign sram_dq_in = sram_oe_n ? 8'h00 : mem[sram_addr[7:0]];
  always @(posedge sram_we_n) if (rst_n) mem[sram_addr[7:0]] = sram_dq_out;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic strobe(input bit is_rd, input bit asel, input logic [7:0] d, input int low_cyc);
    @(negedge clk);
    host_asel = asel;
    host_d_in = d;
    @(negedge clk);
    if (is_rd) host_rd_n = 1'b0; else host_wr_n = 1'b0;
    @(negedge clk);
    s_addr_first = sram_addr;
    for (int i = 1; i < low_cyc; i++) @(negedge clk);
    s_addr = sram_addr; s_d_out = host_d_out; s_dq_out = sram_dq_out;
    s_d_oe = host_d_oe; s_dq_oe = sram_dq_oe; s_ce_n = sram_ce_n;
    s_oe_n = sram_oe_n; s_we_n = sram_we_n;
    host_rd_n = 1'b1;
    host_wr_n = 1'b1;
    for (int i = 0; i < GAP; i++) @(negedge clk);
  endtask

  task automatic load_ptr(input logic [23:0] p);
    strobe(1'b1, 1'b1, 8'h00, 2);                 // dummy read restarts loader
    for (int k = 5; k >= 0; k--) begin
      strobe(1'b0, 1'b1, {4'hA, p[k*4 +: 4]}, 2); // junk in upper half
      check("R3 nibble we_n", {31'd0, s_we_n}, 32'd1);
      check("R3 nibble ce_n", {31'd0, s_ce_n}, 32'd1);
    end
  endtask

  task automatic t_reset();
    check("R1 addr", {9'd0, sram_addr}, 32'd0);
    check("R1 ce_n", {31'd0, sram_ce_n}, 32'd1);
    check("R1 oe_n", {31'd0, sram_oe_n}, 32'd1);
    check("R1 we_n", {31'd0, sram_we_n}, 32'd1);
    check("R1 host oe", {31'd0, host_d_oe}, 32'd0);
    check("R1 dq oe", {31'd0, sram_dq_oe}, 32'd0);
  endtask

  task automatic t_load();
    load_ptr(24'h123456);
    check("R2 pointer msb first", {9'd0, sram_addr}, 32'h123456);
    load_ptr(24'h00ABCD);
    check("R2 pointer reload", {9'd0, sram_addr}, 32'h00ABCD);
  endtask

  task automatic t_write_block();
    logic [7:0] pat [4] = '{8'hAA, 8'h55, 8'h0F, 8'hF0};
    load_ptr(24'h000120);
    for (int i = 0; i < 4; i++) begin
      strobe(1'b0, 1'b0, pat[i], 3);
      check("R4 we_n low", {31'd0, s_we_n}, 32'd0);
      check("R4 ce_n low", {31'd0, s_ce_n}, 32'd0);
      check("R4 oe_n high", {31'd0, s_oe_n}, 32'd1);
      check("R4 dq_oe", {31'd0, s_dq_oe}, 32'd1);
      check("R4 dq_out", {24'd0, s_dq_out}, {24'd0, pat[i]});
      check("R4 addr", {9'd0, s_addr}, 32'h120 + i);
      check("R6 step after write", {9'd0, sram_addr}, 32'h121 + i);
    end
  endtask

  task automatic t_read_block();
    logic [7:0] pat [4] = '{8'hAA, 8'h55, 8'h0F, 8'hF0};
    load_ptr(24'h000120);
    for (int i = 0; i < 4; i++) begin
      strobe(1'b1, 1'b0, 8'h00, 4);
      check("R5 host oe", {31'd0, s_d_oe}, 32'd1);
      check("R5 oe_n low", {31'd0, s_oe_n}, 32'd0);
      check("R5 data", {24'd0, s_d_out}, {24'd0, pat[i]});
      check("R5 addr", {9'd0, s_addr}, 32'h120 + i);
    end
    check("R6 step after reads", {9'd0, sram_addr}, 32'h124);
  endtask

  task automatic t_long_strobe();
    strobe(1'b1, 1'b0, 8'h00, 40);
    check("R6 addr stable in strobe", {9'd0, s_addr}, {9'd0, s_addr_first});
    check("R6 single step long read", {9'd0, sram_addr}, 32'h125);
    strobe(1'b0, 1'b0, 8'h3C, 40);
    check("R6 single step long write", {9'd0, sram_addr}, 32'h126);
  endtask

  task automatic t_overrun();
    load_ptr(24'h3C509E);
    strobe(1'b0, 1'b1, 8'h07, 2);
    check("R7 seventh piece ignored", {9'd0, sram_addr}, 32'h3C509E);
    strobe(1'b1, 1'b1, 8'h00, 3);
    check("R7 dummy read no drive", {31'd0, s_d_oe}, 32'd0);
    check("R7 dummy read keeps pointer", {9'd0, sram_addr}, 32'h3C509E);
    for (int k = 0; k < 6; k++) strobe(1'b0, 1'b1, (k == 4) ? 8'h04 : ((k == 5) ? 8'h02 : 8'h00), 2);
    check("R7 reload after read", {9'd0, sram_addr}, 32'h000042);
  endtask

  task automatic t_wrap();
    load_ptr(24'hFFFFFF);
    check("R8 top bit dropped", {9'd0, sram_addr}, 32'h7FFFFF);
    strobe(1'b0, 1'b0, 8'h99, 2);
    check("R8 wrap to zero", {9'd0, sram_addr}, 32'h0);
    load_ptr(24'h800005);
    check("R8 low 23 bits", {9'd0, sram_addr}, 32'h000005);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_load();
    t_write_block();
    t_read_block();
    t_long_strobe();
    t_overrun();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule